// File: doc/BRIEF.md
# Multi-Target Serial Bus Master with Framed and Raw Transfers

This block gives a host a simple register path to external serial slaves. The host programs a timing and clock-mode profile for each of three slave selects, loads a write-data register, and then writes a control word whose start bit launches one transaction. The block acts as the bus master. It drives SCLK, MOSI and one active-low select, and it samples MISO.

Two transfer kinds are available. A framed transfer sends one address byte and then zero, one or two data bytes. In a framed write the data bytes come from the host. In a framed read the block drives zeros and captures the bytes returned by the slave. A framed write with no data bytes is a plain one-byte command. A raw transfer shifts any length from 1 to 32 bits, full duplex, with no byte structure assumed.

A busy flag covers the whole transaction and the guard period that follows it. Captured data appears right-aligned in the read-data output once the select releases.

Top module: `spi_bridge_master`

## Requirements
- R1: Each select has its own divider N, written through the profile port. Every SCLK half-period during that select's transfer lasts N+1 clock cycles, and the first edge also comes N+1 cycles after the select falls.
- R2: Outside a transfer, SCLK rests at the CPOL level of the most recently started select (select 0 after reset). With CPHA=0, MISO is sampled on each leading edge (the edge that leaves the rest level) and MOSI changes on trailing edges. With CPHA=1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R3: The control word has these fields: select index in bits [1:0], raw mode in bit 2, read in bit 3, data byte count in [5:4], raw length minus one in [10:6], and start in bit 11. A framed write sends wdata[7:0] as the address, then wdata[15:8], then wdata[23:16], each MSB first. Count 0 sends only the address (8 bits), and count 3 behaves as 2.
- R4: A framed read sends the address and then drives MOSI low for the data bytes. Captured bytes are right-aligned in rdata, with the first received byte more significant and the upper bits zero.
- R5: A raw transfer of L+1 bits (L from the length field) sends wdata[L:0] MSB first. It puts the L+1 bits sampled from MISO right-aligned in rdata, with the upper bits zero.
- R6: Only the addressed select goes low, and it stays low for the whole transaction. At most one select is ever low.
- R7: busy rises on the cycle after an accepted start. It stays high until G cycles after the select returns high, where G is that select's guard value.
- R8: A control write is ignored if the start bit is clear, if busy is high, or if the select index is 3.
- R9: rdata changes only when a raw transfer or framed read ends. A framed write leaves it unchanged.
- R10: After reset all selects are high, busy, SCLK and MOSI are low, rdata is zero and every profile is zero.

Ports are listed in the same order as in the module declaration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prof_wr | input | 1 | Profile write strobe |
| prof_sel | input | 2 | Select whose profile is written |
| prof_div | input | DIV_W | Half-period divider N |
| prof_guard | input | GUARD_W | Guard cycles after select release |
| prof_cpol | input | 1 | Clock rest level |
| prof_cpha | input | 1 | Clock phase |
| wdata_wr | input | 1 | Write-data register strobe |
| wdata_in | input | 32 | Write data |
| ctrl_wr | input | 1 | Control register strobe |
| ctrl_in | input | 12 | Control word (fields in R3) |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| cs_n | output | NUM_CS | Active-low selects |
| rdata | output | 32 | Right-aligned read data |
| busy | output | 1 | Transaction or guard in progress |

## Verification
Several kinds of internal fault show up at the pins, each within a predictable time:

- A wrong edge counter or frame length changes the number of SCLK pulses before the select rises. It also truncates or pads the bit stream the bench slave records, so the fault is visible by the end of that transaction.
- A phase or polarity error moves data to the wrong edge. The slave then captures shifted data, and the block returns a shifted word on the same transfer.
- A divider or guard counter that is off by one changes the measured half-period or the busy tail. This shows as a cycle-level miscount on the first affected edge.
- A stuck state machine leaves busy high, and the bench's waits then expire.

// File: rtl/spib_pkg.sv
package spib_pkg;

    localparam int XFER_W   = 32;
    localparam int LEN_W    = $clog2(XFER_W);
    localparam int CS_IDX_W = 2;

    typedef struct packed {
        logic                start;
        logic [LEN_W-1:0]    raw_len_m1;
        logic [1:0]          nbytes;
        logic                rd;
        logic                raw;
        logic [CS_IDX_W-1:0] cs_idx;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_GUARD = 2'd2
    } state_t;

    // Data byte count with the out-of-range code folded onto two.
    function automatic logic [1:0] eff_nbytes(input ctrl_t c);
        return (c.nbytes == 2'd3) ? 2'd2 : c.nbytes;
    endfunction

    // Total number of bits moved by one transaction.
    function automatic logic [LEN_W:0] frame_bits(input ctrl_t c);
        logic [LEN_W:0] n;
        if (c.raw) n = {1'b0, c.raw_len_m1} + 1'b1;
        else       n = (LEN_W+1)'(8) * ((LEN_W+1)'(eff_nbytes(c)) + 1'b1);
        return n;
    endfunction

    function automatic logic [XFER_W-1:0] low_mask(input logic [LEN_W:0] n);
        logic [XFER_W-1:0] m;
        if (n >= (LEN_W+1)'(XFER_W)) m = '1;
        else                          m = (XFER_W'(1) << n) - 1'b1;
        return m;
    endfunction

    // Left-aligned transmit image: bit XFER_W-1 leaves first.
    function automatic logic [XFER_W-1:0] build_tx(input ctrl_t c,
                                                    input logic [XFER_W-1:0] w);
        logic [XFER_W-1:0] t;
        logic [7:0] b1, b2;
        logic [1:0] nb;
        if (c.raw) begin
            t = w << (LEN_W'(XFER_W-1) - c.raw_len_m1);
        end else begin
            nb = eff_nbytes(c);
            b1 = (c.rd || nb < 2'd1) ? 8'h00 : w[15:8];
            b2 = (c.rd || nb < 2'd2) ? 8'h00 : w[23:16];
            t  = {w[7:0], b1, b2, {(XFER_W-24){1'b0}}};
        end
        return t;
    endfunction

    // Which bits of the capture register become read data.
    function automatic logic [XFER_W-1:0] read_mask(input ctrl_t c);
        logic [XFER_W-1:0] m;
        if (c.raw) m = low_mask({1'b0, c.raw_len_m1} + 1'b1);
        else       m = low_mask((LEN_W+1)'(8) * (LEN_W+1)'(eff_nbytes(c)));
        return m;
    endfunction

endpackage

// File: rtl/spib_profile_bank.sv
module spib_profile_bank
    import spib_pkg::*;
#(
    parameter int NUM_CS  = 3,
    parameter int DIV_W   = 8,
    parameter int GUARD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [CS_IDX_W-1:0] wr_sel,
    input  logic [DIV_W-1:0]    wr_div,
    input  logic [GUARD_W-1:0]  wr_guard,
    input  logic                wr_cpol,
    input  logic                wr_cpha,
    input  logic [CS_IDX_W-1:0] rd_sel,
    output logic [DIV_W-1:0]    rd_div,
    output logic [GUARD_W-1:0]  rd_guard,
    output logic                rd_cpol,
    output logic                rd_cpha
);

    logic [DIV_W-1:0]   div_q   [NUM_CS];
    logic [GUARD_W-1:0] guard_q [NUM_CS];
    logic               cpol_q  [NUM_CS];
    logic               cpha_q  [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                div_q[g]   <= '0;
                guard_q[g] <= '0;
                cpol_q[g]  <= 1'b0;
                cpha_q[g]  <= 1'b0;
            end else if (wr && wr_sel == CS_IDX_W'(g)) begin
                div_q[g]   <= wr_div;
                guard_q[g] <= wr_guard;
                cpol_q[g]  <= wr_cpol;
                cpha_q[g]  <= wr_cpha;
            end
        end
    end

    always_comb begin
        rd_div   = '0;
        rd_guard = '0;
        rd_cpol  = 1'b0;
        rd_cpha  = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (rd_sel == CS_IDX_W'(i)) begin
                rd_div   = div_q[i];
                rd_guard = guard_q[i];
                rd_cpol  = cpol_q[i];
                rd_cpha  = cpha_q[i];
            end
        end
    end

endmodule

// File: rtl/spib_tick_gen.sv
module spib_tick_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || clear || !run || tick) cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/spib_shifter.sv
module spib_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         sample_en,
    input  logic         miso,
    output logic         tx_msb,
    output logic [W-1:0] rx
);

    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= load_val;
            rx_q <= '0;
        end else begin
            if (shift_en)  tx_q <= {tx_q[W-2:0], 1'b0};
            if (sample_en) rx_q <= {rx_q[W-2:0], miso};
        end
    end

    assign tx_msb = tx_q[W-1];
    assign rx     = rx_q;

endmodule

// File: rtl/spi_bridge_master.sv
module spi_bridge_master
    import spib_pkg::*;
#(
    parameter int NUM_CS  = 3,
    parameter int DIV_W   = 8,
    parameter int GUARD_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         prof_wr,
    input  logic [CS_IDX_W-1:0]          prof_sel,
    input  logic [DIV_W-1:0]             prof_div,
    input  logic [GUARD_W-1:0]           prof_guard,
    input  logic                         prof_cpol,
    input  logic                         prof_cpha,
    input  logic                         wdata_wr,
    input  logic [XFER_W-1:0]            wdata_in,
    input  logic                         ctrl_wr,
    input  logic [$bits(ctrl_t)-1:0]     ctrl_in,
    input  logic                         miso,
    output logic                         sclk,
    output logic                         mosi,
    output logic [NUM_CS-1:0]            cs_n,
    output logic [XFER_W-1:0]            rdata,
    output logic                         busy
);

    localparam int EV_W = $clog2(2*XFER_W + 1);

    ctrl_t                ctl;
    state_t               state;
    logic [CS_IDX_W-1:0]  cur_idx, sel_idx;
    logic [XFER_W-1:0]    wdata_q, rdata_q, cur_mask, rx_word;
    logic                 cur_upd;
    logic [EV_W-1:0]      ev_cnt, ev_last;
    logic [GUARD_W-1:0]   gcnt;
    logic                 sclk_q;
    logic [NUM_CS-1:0]    cs_n_q;
    logic                 accept, tick, edge_go, finish;
    logic                 odd_edge, sample_en, shift_en, tx_msb;
    logic [DIV_W-1:0]     p_div;
    logic [GUARD_W-1:0]   p_guard;
    logic                 p_cpol, p_cpha;

    assign ctl     = ctrl_t'(ctrl_in);
    assign accept  = ctrl_wr && ctl.start && (state == ST_IDLE)
                     && (int'(ctl.cs_idx) < NUM_CS);
    assign sel_idx = accept ? ctl.cs_idx : cur_idx;

    spib_profile_bank #(
        .NUM_CS (NUM_CS),
        .DIV_W  (DIV_W),
        .GUARD_W(GUARD_W)
    ) prof_i (
        .clk     (clk),
        .rst     (rst),
        .wr      (prof_wr),
        .wr_sel  (prof_sel),
        .wr_div  (prof_div),
        .wr_guard(prof_guard),
        .wr_cpol (prof_cpol),
        .wr_cpha (prof_cpha),
        .rd_sel  (sel_idx),
        .rd_div  (p_div),
        .rd_guard(p_guard),
        .rd_cpol (p_cpol),
        .rd_cpha (p_cpha)
    );

    spib_tick_gen #(
        .CNT_W(DIV_W)
    ) tick_i (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_RUN),
        .clear(accept),
        .limit(p_div),
        .tick (tick)
    );

    // Edge k = ev_cnt+1; odd k leaves the rest level.
    assign edge_go   = (state == ST_RUN) && tick && (ev_cnt != ev_last);
    assign finish    = (state == ST_RUN) && tick && (ev_cnt == ev_last);
    assign odd_edge  = ~ev_cnt[0];
    assign sample_en = edge_go && (odd_edge ^ p_cpha);
    assign shift_en  = edge_go && !(odd_edge ^ p_cpha) && (ev_cnt != '0);

    spib_shifter #(
        .W(XFER_W)
    ) shift_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (build_tx(ctl, wdata_q)),
        .shift_en (shift_en),
        .sample_en(sample_en),
        .miso     (miso),
        .tx_msb   (tx_msb),
        .rx       (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst)           wdata_q <= '0;
        else if (wdata_wr) wdata_q <= wdata_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_idx  <= '0;
            ev_cnt   <= '0;
            ev_last  <= '0;
            gcnt     <= '0;
            sclk_q   <= 1'b0;
            cs_n_q   <= '1;
            rdata_q  <= '0;
            cur_mask <= '0;
            cur_upd  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sclk_q <= p_cpol;
                    if (accept) begin
                        state    <= ST_RUN;
                        cur_idx  <= ctl.cs_idx;
                        ev_cnt   <= '0;
                        ev_last  <= EV_W'({frame_bits(ctl), 1'b0});
                        cs_n_q   <= ~(NUM_CS'(1) << ctl.cs_idx);
                        cur_mask <= read_mask(ctl);
                        cur_upd  <= ctl.raw || ctl.rd;
                    end
                end
                ST_RUN: begin
                    if (edge_go) begin
                        ev_cnt <= ev_cnt + 1'b1;
                        sclk_q <= ~sclk_q;
                    end
                    if (finish) begin
                        cs_n_q <= '1;
                        if (cur_upd) rdata_q <= rx_word & cur_mask;
                        if (p_guard == '0) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_GUARD;
                            gcnt  <= p_guard - 1'b1;
                        end
                    end
                end
                ST_GUARD: begin
                    if (gcnt == '0) state <= ST_IDLE;
                    else            gcnt  <= gcnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sclk  = sclk_q;
    assign mosi  = (state == ST_RUN) && tx_msb;
    assign cs_n  = cs_n_q;
    assign rdata = rdata_q;
    assign busy  = (state != ST_IDLE);

endmodule

// File: rtl/spib_checker.sv
module spib_checker #(
    parameter int NUM_CS = 3,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CS-1:0] cs_n,
    input logic              busy,
    input logic              sclk,
    input logic [DATA_W-1:0] rdata,
    input logic              ctrl_wr,
    input logic [IDX_W-1:0]  cur_idx
);

    // R6: never more than one select low
    p_single_select_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R7: a low select is always covered by busy
    p_busy_covers_select_r7: assert property (@(posedge clk) disable iff (rst)
        !(&cs_n) |-> busy);

    // R8: a control write while busy does not retarget the transfer
    p_start_ignored_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_wr) |=> (cur_idx == $past(cur_idx)));

    // R9: read data moves only as the select releases
    p_rdata_at_end_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> $rose(&cs_n));

    // R2: clock rests during the guard period
    p_clock_quiet_guard_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && (&cs_n) && $past(&cs_n)) |-> $stable(sclk));

endmodule

bind spi_bridge_master spib_checker #(
    .NUM_CS(NUM_CS),
    .IDX_W (spib_pkg::CS_IDX_W),
    .DATA_W(spib_pkg::XFER_W)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .busy   (busy),
    .sclk   (sclk),
    .rdata  (rdata),
    .ctrl_wr(ctrl_wr),
    .cur_idx(cur_idx)
);

// File: tb/spi_bridge_master_tb_top.sv
module spi_bridge_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCS = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prof_wr = 1'b0;
    logic [1:0]  prof_sel = '0;
    logic [7:0]  prof_div = '0;
    logic [7:0]  prof_guard = '0;
    logic        prof_cpol = 1'b0, prof_cpha = 1'b0;
    logic        wdata_wr = 1'b0;
    logic [31:0] wdata_in = '0;
    logic        ctrl_wr = 1'b0;
    logic [11:0] ctrl_in = '0;
    logic        miso = 1'b0;
    logic        sclk, mosi, busy;
    logic [NCS-1:0] cs_n;
    logic [31:0] rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_bridge_master dut_i (
        .clk(clk), .rst(rst),
        .prof_wr(prof_wr), .prof_sel(prof_sel), .prof_div(prof_div),
        .prof_guard(prof_guard), .prof_cpol(prof_cpol), .prof_cpha(prof_cpha),
        .wdata_wr(wdata_wr), .wdata_in(wdata_in),
        .ctrl_wr(ctrl_wr), .ctrl_in(ctrl_in),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .rdata(rdata), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit summary_done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- slave model ----------------
    logic [1:0]  arm_sel = '0;
    logic        arm_cpol = 1'b0, arm_cpha = 1'b0;
    logic [31:0] arm_pat = '0;
    int          arm_id = 0;

    int          seen_id = 0;
    logic        mon_act = 1'b0, mon_done = 1'b0, mon_other = 1'b0, prev_sclk = 1'b0;
    logic [31:0] mon_pat = '0, mon_cap = '0;
    int          mon_bits = 0, mon_hcnt = 0, mon_hmin = 0, mon_hmax = 0;

    always @(negedge clk) begin
        if (arm_id != seen_id) begin
            seen_id   = arm_id;
            mon_act   = 1'b0;
            mon_done  = 1'b0;
            mon_other = 1'b0;
            mon_pat   = arm_pat;
            mon_cap   = '0;
            mon_bits  = 0;
            mon_hmin  = 1000;
            mon_hmax  = 0;
        end
        if (!rst) begin
            for (int i = 0; i < NCS; i++)
                if (i != int'(arm_sel) && !cs_n[i]) mon_other = 1'b1;
            if (!mon_act && !mon_done && !cs_n[arm_sel]) begin
                mon_act   = 1'b1;
                mon_hcnt  = 0;
                prev_sclk = sclk;
                if (!arm_cpha) begin
                    miso    = mon_pat[31];
                    mon_pat = mon_pat << 1;
                end
            end else if (mon_act) begin
                if (cs_n[arm_sel]) begin
                    mon_act  = 1'b0;
                    mon_done = 1'b1;
                end else begin
                    mon_hcnt++;
                    if (sclk != prev_sclk) begin
                        if (mon_hcnt < mon_hmin) mon_hmin = mon_hcnt;
                        if (mon_hcnt > mon_hmax) mon_hmax = mon_hcnt;
                        mon_hcnt  = 0;
                        prev_sclk = sclk;
                        if ((sclk != arm_cpol) != arm_cpha) begin
                            mon_cap = {mon_cap[30:0], mosi};
                            mon_bits++;
                        end else begin
                            miso    = mon_pat[31];
                            mon_pat = mon_pat << 1;
                        end
                    end
                end
            end
        end
    end

    // ---------------- host tasks ----------------
    task automatic write_profile(input logic [1:0] s, input logic [7:0] d, input logic [7:0] g,
                                 input logic pol, input logic pha);
        @(negedge clk);
        prof_wr = 1'b1; prof_sel = s; prof_div = d; prof_guard = g;
        prof_cpol = pol; prof_cpha = pha;
        @(negedge clk);
        prof_wr = 1'b0;
    endtask

    task automatic write_wdata(input logic [31:0] w);
        @(negedge clk);
        wdata_wr = 1'b1; wdata_in = w;
        @(negedge clk);
        wdata_wr = 1'b0;
    endtask

    task automatic write_ctrl(input logic [11:0] c);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_in = c;
        @(negedge clk);
        ctrl_wr = 1'b0;
        #1;
    endtask

    task automatic arm(input logic [1:0] s, input logic pol, input logic pha, input logic [31:0] p);
        @(negedge clk);
        #1;
        arm_sel = s; arm_cpol = pol; arm_cpha = pha; arm_pat = p;
        arm_id++;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!mon_done && n < 5000) begin
            @(negedge clk);
            #1;
            n++;
        end
    endtask

    task automatic count_guard(output int g);
        g = 0;
        while (busy && g < 1000) begin
            @(negedge clk);
            #1;
            g++;
        end
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [1:0]  sel;
        logic [7:0]  div;
        logic [7:0]  guard;
        logic        cpol;
        logic        cpha;
        logic [11:0] ctrl;
        logic [31:0] wdata;
        logic [31:0] pat;
        logic [7:0]  nbits;
        logic [31:0] exp_mosi;
        logic        upd;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd1, 8'd2, 1'b0, 1'b0, 12'h820, 32'h003412C3, 32'h00000000, 8'd24, 32'h00C31234, 1'b0, 32'h0},
        '{2'd1, 8'd0, 8'd0, 1'b1, 1'b1, 12'h801, 32'h00000096, 32'h00000000, 8'd8,  32'h00000096, 1'b0, 32'h0},
        '{2'd2, 8'd2, 8'd3, 1'b0, 1'b1, 12'h82A, 32'h0000002B, 32'hFFA53C00, 8'd24, 32'h002B0000, 1'b1, 32'h0000A53C},
        '{2'd0, 8'd3, 8'd1, 1'b1, 1'b0, 12'h818, 32'h000000D4, 32'h815A0000, 8'd16, 32'h0000D400, 1'b1, 32'h0000005A},
        '{2'd1, 8'd1, 8'd4, 1'b0, 1'b0, 12'hAC5, 32'hFFFFFABC, 32'h9D5F0000, 8'd12, 32'h00000ABC, 1'b1, 32'h000009D5},
        '{2'd2, 8'd0, 8'd0, 1'b1, 1'b1, 12'hFC6, 32'hDEADBEEF, 32'h12345678, 8'd32, 32'hDEADBEEF, 1'b1, 32'h12345678},
        '{2'd0, 8'd0, 8'd5, 1'b1, 1'b1, 12'h804, 32'h00000001, 32'h80000000, 8'd1,  32'h00000001, 1'b1, 32'h00000001},
        '{2'd1, 8'd2, 8'd0, 1'b0, 1'b1, 12'h811, 32'h00007E41, 32'hFFFFFFFF, 8'd16, 32'h0000417E, 1'b0, 32'h0},
        '{2'd2, 8'd1, 8'd1, 1'b0, 1'b0, 12'h832, 32'h77A1B2C3, 32'hFFFFFFFF, 8'd24, 32'h00C3B2A1, 1'b0, 32'h0}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin : main
        logic [31:0] last_rd;
        logic [31:0] m;
        int g;

        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        check("R10 cs_n", 32'(cs_n), 32'h7);
        check("R10 busy", 32'(busy), 32'h0);
        check("R10 sclk", 32'(sclk), 32'h0);
        check("R10 mosi", 32'(mosi), 32'h0);
        check("R10 rdata", rdata, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        last_rd = 32'h0;

        for (int v = 0; v < NV; v++) begin
            write_profile(VECS[v].sel, VECS[v].div, VECS[v].guard, VECS[v].cpol, VECS[v].cpha);
            write_wdata(VECS[v].wdata);
            arm(VECS[v].sel, VECS[v].cpol, VECS[v].cpha, VECS[v].pat);
            write_ctrl(VECS[v].ctrl);
            check("R7 busy after start", 32'(busy), 32'h1);
            wait_done();
            check("R6 select released", 32'(mon_done), 32'h1);
            check("R6 other select idle", 32'(mon_other), 32'h0);
            m = (VECS[v].nbits >= 8'd32) ? 32'hFFFFFFFF : ((32'd1 << VECS[v].nbits) - 1);
            check("R3 R4 R5 bit count", 32'(mon_bits), 32'(VECS[v].nbits));
            check("R3 R4 R5 mosi stream", mon_cap & m, VECS[v].exp_mosi);
            check("R1 min half period", 32'(mon_hmin), 32'(VECS[v].div) + 1);
            check("R1 max half period", 32'(mon_hmax), 32'(VECS[v].div) + 1);
            count_guard(g);
            check("R7 guard length", 32'(g), 32'(VECS[v].guard));
            if (VECS[v].upd) last_rd = VECS[v].exp_rd;
            check("R4 R5 R9 rdata", rdata, last_rd);
            check("R2 sclk rest level", 32'(sclk), 32'(VECS[v].cpol));
        end

        // R8: control write without start bit
        write_ctrl(12'h000);
        check("R8 no start bit", 32'(busy), 32'h0);
        // R8: select index 3
        write_ctrl(12'h803);
        check("R8 index 3 busy", 32'(busy), 32'h0);
        repeat (5) @(negedge clk);
        #1;
        check("R8 index 3 selects", 32'(cs_n), 32'h7);

        // R8: start while busy is dropped
        write_profile(2'd0, 8'd3, 8'd2, 1'b0, 1'b0);
        write_wdata(32'h0000005C);
        arm(2'd0, 1'b0, 1'b0, 32'h0);
        write_ctrl(12'h800);
        repeat (6) @(negedge clk);
        ctrl_wr = 1'b1; ctrl_in = 12'h801;
        @(negedge clk);
        ctrl_wr = 1'b0;
        #1;
        wait_done();
        check("R8 busy start other select", 32'(mon_other), 32'h0);
        check("R8 first transfer intact", mon_cap & 32'hFF, 32'h5C);
        count_guard(g);
        repeat (10) @(negedge clk);
        #1;
        check("R8 no second transfer", 32'(busy), 32'h0);
        check("R8 selects idle", 32'(cs_n), 32'h7);
        check("R9 rdata after framed write", rdata, last_rd);

        // R2: idle level follows profile of last select
        write_profile(2'd0, 8'd3, 8'd2, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        #1;
        check("R2 idle follows cpol", 32'(sclk), 32'h1);

        finish_run();
    end

endmodule